// File: doc/BRIEF.md
# Strobe-Latched Static RAM Cycle Sequencer

This block runs from a system clock and carries out single read and write transactions on an asynchronous static RAM. That RAM captures its address on the falling edge of an active-low enable strobe and has one shared data bus. The host raises a request with a read/write flag, an address and write data. The block then plays out the strobe sequence on the memory pins. It asserts a one-cycle completion pulse, and for reads it returns the data it captured.

Every timing interval is a parameter counted in clock cycles. These are the address setup and hold, the access time, the minimum strobe low and high widths, the data setup and hold, and the minimum strobe-to-strobe cycle. Writes use the ordering in which the write strobe is already low when the enable falls and stays low until after the enable rises, so the RAM never drives the shared bus during a write. A mode input keeps the write strobe low between consecutive writes. Each write is still framed by its own enable pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held, and directly after it, the enable strobe and the write strobe are high (inactive), the data driver is off, busy is low and done is low.
- R2: The address appears on the memory address pins T_ASU cycles before the enable falls. It stays unchanged for exactly T_AHOLD cycles of enable-low, counting the cycle of the fall. It is then driven to all zeros until the next transaction's setup.
- R3: In a read, the write strobe stays high for the whole cycle. The enable stays low for exactly max(T_ELOW, T_ACC) cycles. The read data output carries the memory bus value captured at the end of that low interval.
- R4: The enable stays high for at least T_EHIGH cycles between transactions. Two consecutive falling edges of the enable are never less than T_CYC cycles apart.
- R5: In a write, the write strobe is already low when the enable falls. It does not change while the enable is low, and it is still low in the cycle the enable rises.
- R6: In a write, the enable stays low for exactly max(T_ELOW, T_DSU) cycles. The data driver is on during every enable-low cycle with the latched write data. It remains on for exactly T_DHOLD cycles after the enable rises and is never on outside a write. The data is stored at the latched address.
- R7: Busy rises in the cycle after a request is accepted in the idle state. It stays high through the enable-high recovery, which lasts max(T_EHIGH, T_DHOLD for writes, T_CYC minus the low length minus T_ASU minus 1) cycles. Requests that arrive while busy are ignored.
- R8: When wr_hold_mode is 1, the write strobe stays low after a write, through recovery and idle, until a read is accepted; then it rises before that read's setup. When wr_hold_mode is 0, the write strobe is high in idle.
- R9: Done is high for exactly one cycle per transaction. That cycle is T_ASU plus the low length plus 1 cycles after the request was sampled, and it is the first cycle in which the enable is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transaction request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Transaction address |
| wdata | input | DW | Write data |
| wr_hold_mode | input | 1 | Keep write strobe low between writes |
| busy | output | 1 | Transaction in progress |
| rdata | output | DW | Last read data |
| done | output | 1 | One-cycle completion pulse |
| mem_en_n | output | 1 | Memory enable strobe, address latched on fall |
| mem_we_n | output | 1 | Memory write strobe |
| mem_a | output | AW | Memory address pins |
| mem_dq_o | output | DW | Data driven toward the shared bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | DW | Value observed on the shared bus |

## Verification
The bench attaches a behavioural RAM model that drives invalid, inverted data until T_ACC enable-low cycles have passed, so a read captured too early returns the wrong nibble rather than a plausible one. Isolated writes followed by reads separate correct address latching and data storage from stale or misplaced data. Back-to-back writes in hold mode, followed by a read, separate a write strobe that stays low from one that toggles, and they show that the read still raises it before its enable falls. A request raised in the middle of a busy transaction separates requests that are properly ignored from ones that start a spurious enable pulse or corrupt another location. A bus monitor flags any cycle in which the model and the controller drive the bus together.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int AW      = 10,
  parameter int DW      = 4,
  parameter int T_ASU   = 1,
  parameter int T_AHOLD = 3,
  parameter int T_ACC   = 7,
  parameter int T_ELOW  = 6,
  parameter int T_EHIGH = 3,
  parameter int T_DSU   = 3,
  parameter int T_DHOLD = 1,
  parameter int T_CYC   = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_hold_mode,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          mem_en_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_a,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int L_RD  = (T_ELOW > T_ACC) ? T_ELOW : T_ACC;
  localparam int L_WR  = (T_ELOW > T_DSU) ? T_ELOW : T_DSU;
  localparam int F_RD  = T_CYC - L_RD - T_ASU - 1;
  localparam int F_WR  = T_CYC - L_WR - T_ASU - 1;
  localparam int H_RD  = (T_EHIGH > F_RD) ? T_EHIGH : F_RD;
  localparam int H_W0  = (T_EHIGH > T_DHOLD) ? T_EHIGH : T_DHOLD;
  localparam int H_WR  = (H_W0 > F_WR) ? H_W0 : F_WR;
  localparam int CW    = $clog2(T_CYC + L_RD + L_WR + H_W0 + T_ASU + 2);

  localparam logic [CW-1:0] C_ASU   = CW'(T_ASU - 1);
  localparam logic [CW-1:0] C_AHOLD = CW'(T_AHOLD);
  localparam logic [CW-1:0] C_DHOLD = CW'(T_DHOLD);
  localparam logic [CW-1:0] C_LRD   = CW'(L_RD - 1);
  localparam logic [CW-1:0] C_LWR   = CW'(L_WR - 1);
  localparam logic [CW-1:0] C_HRD   = CW'(H_RD - 1);
  localparam logic [CW-1:0] C_HWR   = CW'(H_WR - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ASU, ST_LOW, ST_HIGH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] rd_q;
  logic          done_q;

  wire [CW-1:0] low_last  = wr_q ? C_LWR : C_LRD;
  wire [CW-1:0] high_last = wr_q ? C_HWR : C_HRD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      a_q    <= '0;
      d_q    <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req) begin
          a_q  <= addr;
          wr_q <= wr;
          d_q  <= wdata;
          cnt  <= '0;
          st   <= ST_ASU;
        end
        ST_ASU: if (cnt == C_ASU) begin
          cnt <= '0;
          st  <= ST_LOW;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (cnt == low_last) begin
          cnt    <= '0;
          st     <= ST_HIGH;
          done_q <= 1'b1;
          if (!wr_q) rd_q <= mem_dq_i;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == high_last) begin
          cnt <= '0;
          st  <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  wire drv_win = (st == ST_LOW) || (st == ST_HIGH && cnt < C_DHOLD);
  wire w_low   = wr_q && ((st == ST_ASU) || drv_win ||
                 (wr_hold_mode && (st == ST_HIGH || st == ST_IDLE)));

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign rdata     = rd_q;
  assign mem_en_n  = (st != ST_LOW);
  assign mem_we_n  = !w_low;
  assign mem_a     = ((st == ST_ASU) || (st == ST_LOW && cnt < C_AHOLD)) ? a_q : '0;
  assign mem_dq_oe = wr_q && drv_win;
  assign mem_dq_o  = mem_dq_oe ? d_q : '0;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int T_ELOW  = 6,
  parameter int T_EHIGH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mem_en_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);

  logic [15:0] lowrun, highrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun  <= '0;
      highrun <= 16'hFFFF;
    end else begin
      lowrun  <= mem_en_n ? '0 : ((lowrun == 16'hFFFF) ? lowrun : lowrun + 1'b1);
      highrun <= !mem_en_n ? '0 : ((highrun == 16'hFFFF) ? highrun : highrun + 1'b1);
    end
  end

  p_e_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_n) |-> (lowrun >= 16'(T_ELOW)));

  p_e_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_n) |-> (highrun >= 16'(T_EHIGH)));

  p_w_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> $stable(mem_we_n));

  p_e_rise_w_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_en_n) && $past(!mem_we_n)) |-> !mem_we_n);

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  p_busy_cover_e_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.T_ELOW(T_ELOW), .T_EHIGH(T_EHIGH)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_en_n(mem_en_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;
  localparam int T_ASU = 1, T_AHOLD = 3, T_ACC = 7, T_ELOW = 6, T_EHIGH = 3;
  localparam int T_DSU = 3, T_DHOLD = 1, T_CYC = 14;
  localparam int LRD = 7, LWR = 6;
  localparam int HRD = 5, HWR = 6;

  logic clk = 0, rst_n = 0, req = 0, wr = 0, hold = 0;
  logic [9:0] addr = '0;
  logic [3:0] wdata = '0, rdata, mem_dq_o, dq_bus;
  logic busy, done, mem_en_n, mem_we_n, mem_dq_oe;
  logic [9:0] mem_a;

  always #10 clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .wr_hold_mode(hold), .busy(busy), .rdata(rdata), .done(done),
    .mem_en_n(mem_en_n), .mem_we_n(mem_we_n), .mem_a(mem_a),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_bus)
  );

  logic [3:0] ram [0:1023];
  logic [3:0] exp_ram [0:1023];
  logic [9:0] lat;
  int mlow = 0;
  wire mdrv = !mem_en_n && mem_we_n;
  wire [3:0] mdat = (mlow >= T_ACC - 1) ? ram[lat] : ~ram[lat];
  assign dq_bus = mdrv ? mdat : (mem_dq_oe ? mem_dq_o : 4'h0);

  always @(negedge mem_en_n) lat = mem_a;
  always @(posedge mem_en_n) if (!mem_we_n && mem_dq_oe) ram[lat] <= mem_dq_o;
  always @(posedge clk) mlow <= mem_en_n ? 0 : mlow + 1;

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  bit exp_wr = 0;
  logic [9:0] exp_addr = '0;
  logic [3:0] exp_wd = '0;
  bit prev_en = 1, prev_oe = 0, had_fall = 0, released = 0;
  int asu_run = 0, low_n = 0, hold_n = 0, high_n = 0, since_fall = 0, oe_post = 0, falls = 0;
  logic [9:0] fall_addr = '0, last_a = '0;
  logic we_fall = 1;

  always @(negedge clk) if (rst_n) begin
    if (prev_en && !mem_en_n) begin
      falls++;
      chk(asu_run >= T_ASU, "R2 setup", asu_run, T_ASU);
      chk(mem_a == exp_addr, "R2 addr", int'(mem_a), int'(exp_addr));
      if (had_fall) chk(since_fall >= T_CYC, "R4 cycle", since_fall, T_CYC);
      if (had_fall) chk(high_n >= T_EHIGH, "R4 high", high_n, T_EHIGH);
      chk(mem_we_n == !exp_wr, exp_wr ? "R5 w at fall" : "R3 w at fall", int'(mem_we_n), int'(!exp_wr));
      low_n = 1; hold_n = 1; released = 0; fall_addr = mem_a; we_fall = mem_we_n;
      since_fall = 1; had_fall = 1;
    end else since_fall++;
    if (!prev_en && !mem_en_n) begin
      low_n++;
      chk(mem_we_n == we_fall, "R5 w steady", int'(mem_we_n), int'(we_fall));
      if (!released && mem_a != fall_addr) begin
        released = 1;
        chk(hold_n == T_AHOLD, "R2 hold", hold_n, T_AHOLD);
        chk(mem_a == 0, "R2 release", int'(mem_a), 0);
      end else if (!released) hold_n++;
    end
    if (!prev_en && mem_en_n) begin
      chk(low_n == (exp_wr ? LWR : LRD), exp_wr ? "R6 low len" : "R3 low len", low_n, exp_wr ? LWR : LRD);
      chk(released, "R2 released", int'(released), 1);
      if (exp_wr) chk(!mem_we_n, "R5 w at rise", int'(mem_we_n), 0);
      high_n = 1; oe_post = 0;
    end else if (mem_en_n) high_n++;
    if (!mem_en_n) chk(mem_dq_oe == exp_wr, "R6 drive while low", int'(mem_dq_oe), int'(exp_wr));
    if (mem_dq_oe) chk(exp_wr && mem_dq_o == exp_wd, "R6 data", int'(mem_dq_o), int'(exp_wd));
    if (mem_dq_oe && mdrv) chk(0, "R6 contention", 1, 0);
    if (mem_en_n && mem_dq_oe) oe_post++;
    if (prev_oe && !mem_dq_oe && mem_en_n) chk(oe_post == T_DHOLD, "R6 hold", oe_post, T_DHOLD);
    if (mem_en_n && mem_a != 0 && mem_a == last_a) asu_run++;
    else if (mem_en_n && mem_a != 0) asu_run = 1;
    else asu_run = 0;
    last_a = mem_a; prev_en = mem_en_n; prev_oe = mem_dq_oe;
  end

  task automatic txn(input bit w, input logic [9:0] a, input logic [3:0] d);
    int k = 0, b = 0;
    int L = w ? LWR : LRD;
    int H = w ? HWR : HRD;
    while (busy) @(negedge clk);
    exp_wr = w; exp_addr = a; exp_wd = d;
    req = 1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    chk(busy, "R7 busy rise", int'(busy), 1);
    k = 1;
    while (!done && k < 100) begin @(negedge clk); k++; end
    chk(k == T_ASU + L + 1, "R9 done time", k, T_ASU + L + 1);
    chk(mem_en_n, "R9 e high at done", int'(mem_en_n), 1);
    if (!w) chk(rdata == exp_ram[a], "R3 rdata", int'(rdata), int'(exp_ram[a]));
    else exp_ram[a] = d;
    @(negedge clk);
    chk(!done, "R9 single pulse", int'(done), 0);
    while (busy && b < 100) begin b++; @(negedge clk); end
    chk(b == H - 1, "R7 recovery", b, H - 1);
  endtask

  task automatic t_reset;
    chk(mem_en_n && mem_we_n && !mem_dq_oe, "R1 mem pins", {mem_en_n, mem_we_n, mem_dq_oe}, 3'b110);
    chk(!busy && !done, "R1 host", {busy, done}, 0);
  endtask

  task automatic t_single;
    txn(1, 10'h005, 4'h3);
    txn(1, 10'h3FF, 4'hC);
    txn(0, 10'h005, 4'h0);
    txn(0, 10'h3FF, 4'h0);
    txn(0, 10'h111, 4'h0);
    @(negedge clk);
    chk(mem_we_n, "R8 idle w high", int'(mem_we_n), 1);
  endtask

  task automatic t_busy_ignore;
    int f0 = falls;
    exp_wr = 1; exp_addr = 10'h0A0; exp_wd = 4'h9;
    req = 1; wr = 1; addr = 10'h0A0; wdata = 4'h9;
    @(negedge clk);
    addr = 10'h0B0; wdata = 4'h6;
    repeat (4) @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
    exp_ram[10'h0A0] = 4'h9;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(falls - f0 == 1, "R7 ignored req", falls - f0, 1);
    txn(0, 10'h0B0, 4'h0);
    txn(0, 10'h0A0, 4'h0);
  endtask

  task automatic t_burst;
    hold = 1;
    for (int i = 1; i < 4; i++) begin
      txn(1, 10'(i * 37), 4'(i + 5));
      @(negedge clk);
      chk(!mem_we_n, "R8 w held low", int'(mem_we_n), 0);
    end
    txn(0, 10'd74, 4'h0);
    txn(0, 10'd111, 4'h0);
    hold = 0;
    txn(1, 10'h200, 4'hE);
    @(negedge clk);
    chk(mem_we_n, "R8 w released", int'(mem_we_n), 1);
    txn(0, 10'h200, 4'h0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ram[i] = 4'(i) ^ 4'hA;
      exp_ram[i] = 4'(i) ^ 4'hA;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_busy_ignore();
    t_burst();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule